// File: doc/BRIEF.md
# Preamble-Sync Serial Record Reader

This block pulls one record off a serial disk bit stream. A start strobe arms it with the number of 16-bit data words the record holds. The block then ignores the line for a fixed number of microsecond ticks, which covers the preamble. After that it hunts for the sync mark: a long run of zero bits closed by a single one bit.

Once in sync, it assembles the commanded number of words, most significant bit first, and presents each one with a one-cycle valid strobe. It then reads one more word and compares it with a running checksum. The checksum starts from a fixed seed and XORs in every data word. At the end of the record the block pulses done, reports whether the checksum matched, and returns to the unsynchronized idle state. Each new record therefore needs its own start and its own sync.

The raw bit input passes through a glitch filter before it is sampled, so short bounces on the line cannot show up as one bits. The bit-valid strobe marks the sampling points in the filtered level.

Top module: `srec_reader`

## Requirements
- R1: After synchronous reset the block is idle: word_valid, done and csum_err are 0 and word_out is 0.
- R2: For PRE_US microsecond ticks after an accepted start, bit strobes are ignored. A complete zero run, one bit and data word sent in that window produce no word_valid.
- R3: Sync needs at least ZERO_BITS consecutive zero bits followed by a one bit. A one bit seen before that count restarts the zero count and does not start word assembly. The sync one bit is not part of the data.
- R4: After sync, every 16 bit strobes form one word, first bit in bit 15. The word appears on word_out with a one-cycle word_valid pulse in the cycle after the 16th strobe.
- R5: Exactly word_count data words are emitted. The following 16 bits are taken as the checksum word and are not emitted. done pulses for one cycle in the cycle after the checksum word's last strobe. A word_count of 0 means the first word after sync is the checksum.
- R6: The checksum is 16'h0151 XORed with every data word. When done pulses, csum_err is 1 exactly when that value differs from the received checksum word. csum_err holds until the next accepted start.
- R7: After done the block is idle. Further bit strobes, including a full zero run, one bit and data, produce no word_valid or done until a new start.
- R8: A change of the raw bit level reaches the sampler only after it has held for FILT_CYC consecutive clocks. A one pulse shorter than that, present at a strobe, is read as a zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| start | input | 1 | Begin a record read; ignored while busy |
| word_count | input | CNT_W | Number of data words in the record |
| bit_valid | input | 1 | Strobe: sample the filtered bit now |
| bit_in | input | 1 | Raw serial data bit level |
| word_out | output | 16 | Assembled data word |
| word_valid | output | 1 | One-cycle strobe for word_out |
| done | output | 1 | One-cycle pulse at record end |
| csum_err | output | 1 | Checksum mismatch of the last record |

## Verification
A vector table drives records of several lengths with words of mixed bit patterns: all ones, all zeros, single edge bits and alternating nibbles. Each table entry has either a correct or a corrupted checksum, so the tests separate bit ordering, word counting and checksum comparison. Directed records add four cases, each with its own failure it exposes:
- Noise in the preamble exposes an early sync.
- A short zero run closed by a one exposes sync being taken on too few zeros.
- Glitched zero bits expose a missing filter.
- Bits sent after done expose a reader that stays synchronized.

A record with zero words checks that the first word after sync is taken as the checksum.

// File: rtl/srec_pkg.sv
package srec_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_PRE  = 2'd1,
    HS_HUNT = 2'd2,
    HS_LOCK = 2'd3
  } hunt_state_t;

  localparam logic [15:0] CSUM_SEED = 16'h0151;
  localparam int WORD_W = 16;
endpackage

// File: rtl/srec_glitch_filter.sv
module srec_glitch_filter #(
  parameter int FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic clean
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam logic [FW-1:0] LAST = FW'(FILT_CYC - 1);

  logic [FW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      clean   <= 1'b0;
      run_cnt <= '0;
    end else if (raw_in == clean) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      clean   <= raw_in;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R8: the filtered level only takes a value the raw input held just before
  p_filter_follows_r8: assert property (@(posedge clk) disable iff (rst)
    (clean != $past(clean)) |-> ($past(raw_in) == clean));
endmodule

// File: rtl/srec_sync_hunt.sv
module srec_sync_hunt
  import srec_pkg::*;
#(
  parameter int PRE_US    = 200,
  parameter int ZERO_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic release_lock,
  input  logic us_tick,
  input  logic bit_stb,
  input  logic bit_val,
  output logic busy,
  output logic locked
);
  localparam int PW = $clog2(PRE_US + 1);
  localparam int ZW = $clog2(ZERO_BITS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_US - 1);
  localparam logic [ZW-1:0] ZMAX     = ZW'(ZERO_BITS);

  hunt_state_t   st;
  logic [PW-1:0] pre_cnt;
  logic [ZW-1:0] zero_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= HS_IDLE;
      pre_cnt  <= '0;
      zero_cnt <= '0;
    end else begin
      unique case (st)
        HS_IDLE: if (arm) begin
          st      <= HS_PRE;
          pre_cnt <= '0;
        end
        HS_PRE: if (us_tick) begin
          if (pre_cnt == PRE_LAST) begin
            st       <= HS_HUNT;
            zero_cnt <= '0;
          end else begin
            pre_cnt <= pre_cnt + 1'b1;
          end
        end
        HS_HUNT: if (bit_stb) begin
          if (!bit_val) begin
            if (zero_cnt != ZMAX) zero_cnt <= zero_cnt + 1'b1;
          end else if (zero_cnt == ZMAX) begin
            st <= HS_LOCK;
          end else begin
            zero_cnt <= '0;
          end
        end
        HS_LOCK: if (release_lock) st <= HS_IDLE;
        default: st <= HS_IDLE;
      endcase
    end
  end

  assign busy   = (st != HS_IDLE);
  assign locked = (st == HS_LOCK);

  // R2: no lock can be reached straight out of the blind preamble
  p_blind_preamble_r2: assert property (@(posedge clk) disable iff (rst)
    (st == HS_PRE) |=> (st != HS_LOCK));
  // R3: lock is entered only on a one-bit strobe after a full zero run
  p_lock_on_one_r3: assert property (@(posedge clk) disable iff (rst)
    (st == HS_HUNT && !(bit_stb && bit_val && zero_cnt == ZMAX)) |=> !locked);
  // R7: record end drops sync
  p_unlock_after_done_r7: assert property (@(posedge clk) disable iff (rst)
    (locked && release_lock) |=> !locked);
endmodule

// File: rtl/srec_word_unit.sv
module srec_word_unit
  import srec_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  input  logic             run,
  input  logic             bit_stb,
  input  logic             bit_val,
  output logic [15:0]      word_out,
  output logic             word_valid,
  output logic             done,
  output logic             csum_err
);
  logic             active;
  logic             in_csum;
  logic [CNT_W-1:0] left;
  logic [3:0]       bit_idx;
  logic [14:0]      sh;
  logic [15:0]      csum;
  logic [15:0]      nxt_word;

  assign nxt_word = {sh, bit_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      in_csum    <= 1'b0;
      left       <= '0;
      bit_idx    <= '0;
      sh         <= '0;
      csum       <= CSUM_SEED;
      word_out   <= '0;
      word_valid <= 1'b0;
      done       <= 1'b0;
      csum_err   <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      done       <= 1'b0;
      if (load) begin
        active   <= 1'b1;
        left     <= count;
        in_csum  <= (count == '0);
        bit_idx  <= '0;
        csum     <= CSUM_SEED;
        csum_err <= 1'b0;
      end else if (active && run && bit_stb) begin
        sh      <= nxt_word[14:0];
        bit_idx <= bit_idx + 1'b1;
        if (bit_idx == 4'd15) begin
          if (!in_csum) begin
            word_out   <= nxt_word;
            word_valid <= 1'b1;
            csum       <= csum ^ nxt_word;
            left       <= left - 1'b1;
            if (left == CNT_W'(1)) in_csum <= 1'b1;
          end else begin
            done     <= 1'b1;
            csum_err <= (nxt_word != csum);
            active   <= 1'b0;
          end
        end
      end
    end
  end

  // R4: words are only produced while synchronized
  p_word_needs_lock_r4: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(run));
  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: an error can only appear together with done
  p_err_at_done_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(csum_err) |-> done);
endmodule

// File: rtl/srec_reader.sv
module srec_reader
  import srec_pkg::*;
#(
  parameter int PRE_US    = 200,
  parameter int ZERO_BITS = 32,
  parameter int FILT_CYC  = 3,
  parameter int CNT_W     = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             us_tick,
  input  logic             start,
  input  logic [CNT_W-1:0] word_count,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic [15:0]      word_out,
  output logic             word_valid,
  output logic             done,
  output logic             csum_err
);
  logic clean_bit;
  logic busy;
  logic locked;
  logic arm;

  assign arm = start && !busy;

  srec_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk    (clk),
    .rst    (rst),
    .raw_in (bit_in),
    .clean  (clean_bit)
  );

  srec_sync_hunt #(.PRE_US(PRE_US), .ZERO_BITS(ZERO_BITS)) u_hunt (
    .clk          (clk),
    .rst          (rst),
    .arm          (arm),
    .release_lock (done),
    .us_tick      (us_tick),
    .bit_stb      (bit_valid),
    .bit_val      (clean_bit),
    .busy         (busy),
    .locked       (locked)
  );

  srec_word_unit #(.CNT_W(CNT_W)) u_word (
    .clk        (clk),
    .rst        (rst),
    .load       (arm),
    .count      (word_count),
    .run        (locked),
    .bit_stb    (bit_valid),
    .bit_val    (clean_bit),
    .word_out   (word_out),
    .word_valid (word_valid),
    .done       (done),
    .csum_err   (csum_err)
  );

  // R7: once idle, nothing is emitted without a new start
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !word_valid);
endmodule

// File: tb/srec_reader_tb.sv
module srec_reader_tb;
  localparam int PRE_US = 200;
  localparam int CNT_W  = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic us_tick = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] word_count = '0;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic [15:0] word_out;
  logic word_valid, done, csum_err;

  int n_chk = 0;
  int n_fail = 0;
  int ticks = 0;
  int ngot = 0;
  int ndone = 0;
  logic last_err = 1'b0;
  logic [15:0] got [0:7];
  int cyc = 0;

  always #5 clk = ~clk;

  srec_reader #(.PRE_US(PRE_US), .ZERO_BITS(32), .FILT_CYC(3), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .us_tick(us_tick), .start(start), .word_count(word_count),
    .bit_valid(bit_valid), .bit_in(bit_in), .word_out(word_out),
    .word_valid(word_valid), .done(done), .csum_err(csum_err)
  );

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    us_tick <= (tdiv == 3);
    if (us_tick) ticks <= ticks + 1;
    if (!rst && word_valid) begin
      if (ngot < 8) got[ngot] <= word_out;
      ngot <= ngot + 1;
    end
    if (!rst && done) begin
      ndone <= ndone + 1;
      last_err <= csum_err;
    end
  end

  typedef struct packed {
    logic [2:0]  n;
    logic [63:0] w;
    logic        bad;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{n: 3'd3, w: 64'hA5C3_0001_8000_0000, bad: 1'b0},
    '{n: 3'd4, w: 64'hFFFF_0000_1234_F0F0, bad: 1'b0},
    '{n: 3'd2, w: 64'h0151_7E7E_0000_0000, bad: 1'b1},
    '{n: 3'd1, w: 64'h8001_0000_0000_0000, bad: 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    @(negedge clk) bit_in = b;
    repeat (5) @(negedge clk);
    if (glitch && !b) begin
      bit_in = 1'b1;
      @(negedge clk) bit_valid = 1'b1;
      @(negedge clk) begin bit_valid = 1'b0; bit_in = b; end
    end else begin
      bit_valid = 1'b1;
      @(negedge clk) bit_valid = 1'b0;
    end
  endtask

  task automatic send_word(input logic [15:0] w, input bit glitch);
    for (int i = 15; i >= 0; i--) send_bit(w[i], glitch);
  endtask

  task automatic send_sync(input bit glitch);
    for (int i = 0; i < 40; i++) send_bit(1'b0, glitch);
    send_bit(1'b1, 1'b0);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 600 && ndone == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // mode: 0 plain, 1 preamble noise, 2 short false sync, 3 glitched zeros
  task automatic run_rec(input int n, input logic [63:0] w, input bit bad, input int mode);
    logic [15:0] cs;
    int t0;
    cs = 16'h0151;
    for (int i = 0; i < n; i++) cs ^= w[63-16*i -: 16];
    if (bad) cs ^= 16'h0001;
    @(negedge clk);
    ngot = 0; ndone = 0;
    start = 1'b1; word_count = CNT_W'(n);
    t0 = ticks;
    @(negedge clk) start = 1'b0;
    if (mode == 1) begin
      send_sync(1'b0);
      send_word(16'hAAAA, 1'b0);
    end
    while (ticks - t0 < PRE_US + 5) @(negedge clk);
    if (mode == 2) begin
      for (int i = 0; i < 20; i++) send_bit(1'b0, 1'b0);
      send_bit(1'b1, 1'b0);
    end
    send_sync(mode == 3);
    for (int i = 0; i < n; i++) send_word(w[63-16*i -: 16], mode == 3);
    send_word(cs, 1'b0);
    wait_done();
  endtask

  task automatic check_rec(input string req, input int n, input logic [63:0] w, input bit bad);
    chk(ngot == n, req, "word count", ngot, n);
    for (int i = 0; i < n && i < 4; i++)
      chk(got[i] == w[63-16*i -: 16], req, "word value", got[i], w[63-16*i -: 16]);
    chk(ndone == 1, "R5", "done pulses", ndone, 1);
    chk(last_err == bad, "R6", "csum_err", last_err, bad);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!word_valid && !done && !csum_err && word_out == 16'h0, "R1", "reset outputs",
        {word_valid, done, csum_err}, 0);

    // table walk: R4 bit order, R5 count, R6 checksum
    for (int v = 0; v < 4; v++) begin
      run_rec(VEC[v].n, VEC[v].w, VEC[v].bad, 0);
      check_rec("R4", VEC[v].n, VEC[v].w, VEC[v].bad);
    end

    // R5 zero-length record: first word after sync is the checksum
    run_rec(0, 64'h0, 1'b0, 0);
    check_rec("R5", 0, 64'h0, 1'b0);

    // R2 noise inside the preamble is ignored
    run_rec(2, 64'h1357_9BDF_0000_0000, 1'b0, 1);
    check_rec("R2", 2, 64'h1357_9BDF_0000_0000, 1'b0);

    // R3 a one after a short zero run does not sync
    run_rec(2, 64'hC0DE_0042_0000_0000, 1'b0, 2);
    check_rec("R3", 2, 64'hC0DE_0042_0000_0000, 1'b0);

    // R8 short pulses on zero bits are filtered out
    run_rec(2, 64'h0000_4000_0000_0000, 1'b0, 3);
    check_rec("R8", 2, 64'h0000_4000_0000_0000, 1'b0);

    // R6 error flag holds after done until next start
    run_rec(1, 64'h7777_0000_0000_0000, 1'b1, 0);
    repeat (20) @(negedge clk);
    chk(csum_err == 1'b1, "R6", "csum_err held", csum_err, 1);

    // R7 stream after done without start produces nothing
    ngot = 0; ndone = 0;
    send_sync(1'b0);
    send_word(16'h5A5A, 1'b0);
    send_word(16'h0151, 1'b0);
    repeat (5) @(negedge clk);
    chk(ngot == 0, "R7", "words without start", ngot, 0);
    chk(ndone == 0, "R7", "done without start", ndone, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule